// File: doc/BRIEF.md
# Dual-Processor Mailbox FIFO Link

This block joins two processors, called side A and side B, through a pair of word queues. Each queue runs in one direction. A word that one side writes to its data address enters its outbound queue, and the opposite side reads that word from its own data address. Each side also has a 16-bit control and status word. That word reports the state of the outbound queue and of the inbound queue, holds an enable and two interrupt-enable bits, and carries a sticky misuse flag. The misuse flag is cleared by writing a one to it.

Each side connects through a simple single-cycle register port with select, write strobe, a one-bit address and 32-bit data. Address 0 selects the control word and address 1 selects the data word. Read data is combinational. A data-word read pops the inbound queue at the closing clock edge. For each side the block drives two level outputs, "outbound queue empty" and "inbound queue holds data". A separate interrupt-flag block consumes them.

Each side has its own misuse tracker, a two-state machine. The state ERR_CLEAR takes the transition *raise* to ERR_RAISED on a push into a full queue or a pop from an empty queue while the side is enabled. ERR_RAISED takes the transition *acknowledge* back to ERR_CLEAR when the control word is written with bit 14 set. In every other case each state holds.

Top module: `ipc_link`

## Requirements
- R1: After reset both control words read 0x0101 (both queues empty, every enable off, no error), both interrupt outputs of both sides are low, and a data-word read returns zero.
- R2: A control write (address 0) stores only bit 2 (outbound-empty interrupt enable), bit 10 (inbound-ready interrupt enable) and bit 15 (link enable). Bits 0, 1, 8, 9 and 14 keep reporting status, and bits 3–7, 11–13 and 16–31 read as zero.
- R3: While enabled, a data write (address 1) appends the word to the outbound queue. From the next cycle the local bit 0 (outbound empty) reads 0 and the peer's bit 8 (inbound empty) reads 0. The peer reads words in the order they were written.
- R4: Each queue holds 16 words. With 16 stored, the writer's bit 1 (outbound full) and the reader's bit 9 (inbound full) read 1.
- R5: A data write into a full queue while enabled is dropped and sets the writer's bit 14 (error).
- R6: A data read from an empty inbound queue while enabled leaves the queue unchanged, returns the last word read successfully from that queue, and sets the reader's bit 14.
- R7: A control write with bit 14 set clears the error flag.
- R8: A control write with bit 3 set empties the local outbound queue. In the next cycle the local bits 0/1 read 1/0 and the peer's bits 8/9 read 1/0.
- R9: While bit 15 is 0, data writes and data reads on that side change no queue and raise no error, and a data read returns zero. Status bits still follow the queue contents.
- R10: The outbound-empty interrupt output is high exactly when bits 15, 2 and 0 are all 1. The inbound-ready interrupt output is high exactly when bits 15 and 10 are 1 and bit 8 is 0.
- R11: A read that takes the last word of a queue makes the reader's bit 8 and the writer's bit 0 read 1 in the same following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Side A access strobe |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 1 | Side A address: 0 control, 1 data |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| a_irq_tx_empty | output | 1 | Side A outbound-empty interrupt level |
| a_irq_rx_ready | output | 1 | Side A inbound-ready interrupt level |
| b_sel | input | 1 | Side B access strobe |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 1 | Side B address: 0 control, 1 data |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq_tx_empty | output | 1 | Side B outbound-empty interrupt level |
| b_irq_rx_ready | output | 1 | Side B inbound-ready interrupt level |

## Verification
A wrong queue count appears in the cycle after the faulty edge. Both sides' status words show it, because the writer and the reader decode the same counter, so a mismatch between the two sides points to a coupling fault. A wrong read pointer or a wrong held last word appears only on the read that uses it. The bench therefore checks every popped value against the order of the words written, including the value returned by a read from an empty queue. A misuse tracker stuck in ERR_RAISED shows as bit 14 still set on the status read right after an acknowledge, and one that never raises shows as bit 14 clear right after the misuse.

// File: rtl/ipc_link_pkg.sv
package ipc_link_pkg;
    localparam int CTL_W       = 16;
    localparam int B_TX_EMPTY  = 0;
    localparam int B_TX_FULL   = 1;
    localparam int B_TX_IE     = 2;
    localparam int B_TX_FLUSH  = 3;
    localparam int B_RX_EMPTY  = 8;
    localparam int B_RX_FULL   = 9;
    localparam int B_RX_IE     = 10;
    localparam int B_ERR       = 14;
    localparam int B_EN        = 15;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_CTL_RD,
        OP_CTL_WR,
        OP_DATA_WR,
        OP_DATA_RD
    } bus_op_e;

    typedef enum logic {
        ERR_CLEAR,
        ERR_RAISED
    } err_state_e;
endpackage

// File: rtl/ipc_link_queue.sv
module ipc_link_queue #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          clr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] head_o,
    output logic [DW-1:0] last_o,
    output logic          empty_o,
    output logic          full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] last_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign head_o  = mem[rp_q];
    assign last_o  = last_q;
    assign do_push = push_i && !full_o && !clr_i;
    assign do_pop  = pop_i && !empty_o && !clr_i;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
            last_q <= '0;
        end else if (clr_i) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= step(wp_q);
            if (do_pop) begin
                rp_q   <= step(rp_q);
                last_q <= mem[rp_q];
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R4: occupancy never passes the depth
    assert_count_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R8: a flush leaves the queue empty
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> empty_o);

    // R5: a write into a full queue does not move the write pointer
    assert_full_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !clr_i) |=> (full_o && $stable(wp_q)));
endmodule

// File: rtl/ipc_link_side.sv
module ipc_link_side
    import ipc_link_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tx_empty,
    input  logic          tx_full,
    input  logic          rx_empty,
    input  logic          rx_full,
    input  logic [DW-1:0] rx_head,
    input  logic [DW-1:0] rx_last,
    output logic          push_o,
    output logic          pop_o,
    output logic          flush_o,
    output logic          irq_tx_empty_o,
    output logic          irq_rx_ready_o
);
    bus_op_e    op;
    err_state_e err_q, err_d;
    logic       en_q, tx_ie_q, rx_ie_q;
    logic       misuse, ack;
    logic [CTL_W-1:0] status;

    always_comb begin
        if (!bus_sel)       op = OP_IDLE;
        else if (!bus_addr) op = bus_we ? OP_CTL_WR : OP_CTL_RD;
        else                op = bus_we ? OP_DATA_WR : OP_DATA_RD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            tx_ie_q <= 1'b0;
            rx_ie_q <= 1'b0;
        end else if (op == OP_CTL_WR) begin
            en_q    <= bus_wdata[B_EN];
            tx_ie_q <= bus_wdata[B_TX_IE];
            rx_ie_q <= bus_wdata[B_RX_IE];
        end
    end

    assign misuse = en_q && (((op == OP_DATA_WR) && tx_full) ||
                             ((op == OP_DATA_RD) && rx_empty));
    assign ack    = (op == OP_CTL_WR) && bus_wdata[B_ERR];

    // misuse tracker: state register
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= ERR_CLEAR;
        else        err_q <= err_d;
    end

    // misuse tracker: transitions
    always_comb begin
        err_d = err_q;
        unique case (err_q)
            ERR_CLEAR:  if (misuse) err_d = ERR_RAISED;
            ERR_RAISED: if (ack)    err_d = ERR_CLEAR;
            default:    err_d = ERR_CLEAR;
        endcase
    end

    always_comb begin
        status             = '0;
        status[B_TX_EMPTY] = tx_empty;
        status[B_TX_FULL]  = tx_full;
        status[B_TX_IE]    = tx_ie_q;
        status[B_RX_EMPTY] = rx_empty;
        status[B_RX_FULL]  = rx_full;
        status[B_RX_IE]    = rx_ie_q;
        status[B_ERR]      = (err_q == ERR_RAISED);
        status[B_EN]       = en_q;
    end

    // outputs
    always_comb begin
        bus_rdata = '0;
        push_o    = 1'b0;
        pop_o     = 1'b0;
        flush_o   = 1'b0;
        unique case (op)
            OP_CTL_RD:  bus_rdata = {{(DW-CTL_W){1'b0}}, status};
            OP_CTL_WR:  flush_o   = bus_wdata[B_TX_FLUSH];
            OP_DATA_WR: push_o    = en_q;
            OP_DATA_RD: begin
                pop_o     = en_q;
                bus_rdata = !en_q ? '0 : (rx_empty ? rx_last : rx_head);
            end
            default: ;
        endcase
    end

    assign irq_tx_empty_o = en_q && tx_ie_q && tx_empty;
    assign irq_rx_ready_o = en_q && rx_ie_q && !rx_empty;

    // R6: an enabled read of an empty inbound queue raises the flag
    assert_empty_read_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr && !bus_we && en_q && rx_empty) |=> status[B_ERR]);

    // R7: acknowledge clears the flag
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !bus_addr && bus_wdata[B_ERR]) |=> !status[B_ERR]);

    // R9: data accesses while disabled leave the flag alone
    assert_disabled_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && bus_sel && bus_addr) |=> $stable(err_q));
endmodule

// File: rtl/ipc_link.sv
module ipc_link #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_sel,
    input  logic          a_we,
    input  logic          a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq_tx_empty,
    output logic          a_irq_rx_ready,
    input  logic          b_sel,
    input  logic          b_we,
    input  logic          b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq_tx_empty,
    output logic          b_irq_rx_ready
);
    localparam int NSIDE = 2;

    logic [NSIDE-1:0] sel, we, addr;
    logic [DW-1:0]    wdata [NSIDE];
    logic [DW-1:0]    rdata [NSIDE];
    logic [DW-1:0]    q_head [NSIDE];
    logic [DW-1:0]    q_last [NSIDE];
    logic [NSIDE-1:0] push, pop, flush, q_empty, q_full, irq_tx, irq_rx;

    assign sel      = {b_sel, a_sel};
    assign we       = {b_we, a_we};
    assign addr     = {b_addr, a_addr};
    assign wdata[0] = a_wdata;
    assign wdata[1] = b_wdata;
    assign a_rdata  = rdata[0];
    assign b_rdata  = rdata[1];
    assign a_irq_tx_empty = irq_tx[0];
    assign a_irq_rx_ready = irq_rx[0];
    assign b_irq_tx_empty = irq_tx[1];
    assign b_irq_rx_ready = irq_rx[1];

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam int P = NSIDE - 1 - s;

        // queue s carries words written by side s to side P
        ipc_link_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (push[s]),
            .pop_i   (pop[P]),
            .clr_i   (flush[s]),
            .wdata_i (wdata[s]),
            .head_o  (q_head[s]),
            .last_o  (q_last[s]),
            .empty_o (q_empty[s]),
            .full_o  (q_full[s])
        );

        ipc_link_side #(.DW(DW)) u_side (
            .clk            (clk),
            .rst_n          (rst_n),
            .bus_sel        (sel[s]),
            .bus_we         (we[s]),
            .bus_addr       (addr[s]),
            .bus_wdata      (wdata[s]),
            .bus_rdata      (rdata[s]),
            .tx_empty       (q_empty[s]),
            .tx_full        (q_full[s]),
            .rx_empty       (q_empty[P]),
            .rx_full        (q_full[P]),
            .rx_head        (q_head[P]),
            .rx_last        (q_last[P]),
            .push_o         (push[s]),
            .pop_o          (pop[s]),
            .flush_o        (flush[s]),
            .irq_tx_empty_o (irq_tx[s]),
            .irq_rx_ready_o (irq_rx[s])
        );

        // R3: an accepted write makes the queue non-empty for the peer
        assert_push_reaches_peer_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (push[s] && !q_full[s] && !flush[s]) |=> !q_empty[s]);
    end
endmodule

// File: tb/ipc_link_test.sv
`timescale 1ns/1ps
module ipc_link_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_sel = 0, a_we = 0, a_addr = 0;
    logic        b_sel = 0, b_we = 0, b_addr = 0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq_tx_empty, a_irq_rx_ready, b_irq_tx_empty, b_irq_rx_ready;

    int tests = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ipc_link uut (
        .clk(clk), .rst_n(rst_n),
        .a_sel(a_sel), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .a_irq_tx_empty(a_irq_tx_empty), .a_irq_rx_ready(a_irq_rx_ready),
        .b_sel(b_sel), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .b_irq_tx_empty(b_irq_tx_empty), .b_irq_rx_ready(b_irq_rx_ready)
    );

    // {req[3:0], side, we, addr, wdata[31:0], check, expect[31:0]}
    localparam int NV = 17;
    localparam logic [71:0] VEC [0:NV-1] = '{
        {4'd2,  1'b0, 1'b1, 1'b0, 32'h0000_8404, 1'b0, 32'h0},           // A enable
        {4'd2,  1'b1, 1'b1, 1'b0, 32'h0000_8404, 1'b0, 32'h0},           // B enable
        {4'd2,  1'b0, 1'b0, 1'b0, 32'h0,         1'b1, 32'h0000_8505},   // R2
        {4'd3,  1'b0, 1'b1, 1'b1, 32'h1111_1111, 1'b0, 32'h0},
        {4'd3,  1'b0, 1'b1, 1'b1, 32'h2222_2222, 1'b0, 32'h0},
        {4'd3,  1'b0, 1'b0, 1'b0, 32'h0,         1'b1, 32'h0000_8504},   // R3
        {4'd3,  1'b1, 1'b0, 1'b0, 32'h0,         1'b1, 32'h0000_8405},   // R3
        {4'd3,  1'b1, 1'b0, 1'b1, 32'h0,         1'b1, 32'h1111_1111},   // R3
        {4'd3,  1'b1, 1'b0, 1'b1, 32'h0,         1'b1, 32'h2222_2222},   // R3
        {4'd11, 1'b0, 1'b0, 1'b0, 32'h0,         1'b1, 32'h0000_8505},   // R11
        {4'd11, 1'b1, 1'b0, 1'b0, 32'h0,         1'b1, 32'h0000_8505},   // R11
        {4'd6,  1'b1, 1'b0, 1'b1, 32'h0,         1'b1, 32'h2222_2222},   // R6
        {4'd6,  1'b1, 1'b0, 1'b0, 32'h0,         1'b1, 32'h0000_C505},   // R6
        {4'd7,  1'b1, 1'b1, 1'b0, 32'h0000_C404, 1'b0, 32'h0},
        {4'd7,  1'b1, 1'b0, 1'b0, 32'h0,         1'b1, 32'h0000_8505},   // R7
        {4'd2,  1'b0, 1'b1, 1'b0, 32'hFFFF_BFF7, 1'b0, 32'h0},
        {4'd2,  1'b0, 1'b0, 1'b0, 32'h0,         1'b1, 32'h0000_8505}    // R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input bit side, input bit w, input bit ad,
                          input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        if (side) begin b_sel = 1; b_we = w; b_addr = ad; b_wdata = d; end
        else      begin a_sel = 1; a_we = w; a_addr = ad; a_wdata = d; end
        #1;
        rd = side ? b_rdata : a_rdata;
        @(posedge clk);
        #1;
        a_sel = 0; b_sel = 0; a_we = 0; b_we = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        access(0, 0, 0, 0, rd); check("R1", rd, 32'h0000_0101);
        access(1, 0, 0, 0, rd); check("R1", rd, 32'h0000_0101);
        check("R1", {28'd0, a_irq_tx_empty, a_irq_rx_ready, b_irq_tx_empty, b_irq_rx_ready}, 32'h0);
        access(0, 0, 1, 0, rd); check("R1", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [71:0] v;
            v = VEC[i];
            access(v[67], v[66], v[65], v[64:33], rd);
            if (v[32]) check($sformatf("R%0d", v[71:68]), rd, v[31:0]);
        end

        // R4: fill to depth
        for (int i = 0; i < 16; i++) access(0, 1, 1, 32'hA000_0000 + i, rd);
        access(0, 0, 0, 0, rd); check("R4", rd, 32'h0000_8506);
        access(1, 0, 0, 0, rd); check("R4", rd, 32'h0000_8605);
        // R5: write into full dropped, error raised
        access(0, 1, 1, 32'hDEAD_BEEF, rd);
        access(0, 0, 0, 0, rd); check("R5", rd, 32'h0000_C506);
        access(1, 0, 1, 0, rd); check("R5", rd, 32'hA000_0000);
        for (int i = 1; i < 15; i++) access(1, 0, 1, 0, rd);
        access(1, 0, 1, 0, rd); check("R5", rd, 32'hA000_000F);
        access(1, 0, 0, 0, rd); check("R5", rd, 32'h0000_8505);
        access(0, 1, 0, 32'h0000_C404, rd);
        // R8: refill three then flush
        for (int i = 0; i < 3; i++) access(0, 1, 1, 32'hB000_0000 + i, rd);
        access(0, 1, 0, 32'h0000_840C, rd);
        access(0, 0, 0, 0, rd); check("R8", rd, 32'h0000_8505);
        access(1, 0, 0, 0, rd); check("R8", rd, 32'h0000_8505);
        access(1, 0, 1, 0, rd); check("R8", rd, 32'hA000_000F);
        access(1, 1, 0, 32'h0000_C404, rd);

        // R10: interrupt levels
        check("R10", {30'd0, a_irq_tx_empty, b_irq_rx_ready}, 32'h2);
        access(0, 1, 1, 32'h0000_0077, rd);
        check("R10", {30'd0, a_irq_tx_empty, b_irq_rx_ready}, 32'h1);
        access(1, 1, 0, 32'h0000_8000, rd);
        check("R10", {31'd0, b_irq_rx_ready}, 32'h0);

        // R9: disabled side ignores data accesses
        access(0, 1, 0, 32'h0, rd);
        access(0, 1, 1, 32'h0000_0099, rd);
        access(0, 0, 1, 0, rd); check("R9", rd, 32'h0);
        access(0, 0, 0, 0, rd); check("R9", rd, 32'h0000_0100);
        access(1, 0, 0, 0, rd); check("R9", rd, 32'h0000_8001);
        access(1, 0, 1, 0, rd); check("R9", rd, 32'h0000_0077);
        access(1, 0, 1, 0, rd); check("R9", rd, 32'h0000_0077);
        check("R10", {30'd0, a_irq_tx_empty, a_irq_rx_ready}, 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule